// File: doc/BRIEF.md
# Bit-Serial Binary-Input Neuron Slice

This block is a small array of eight threshold neurons that all listen to one shared stream of single-bit inputs. Each neuron keeps a signed 16-bit weight for each of its eight input positions, plus its own signed 16-bit threshold. Each arriving input bit is multiplied by the weights one weight bit per clock, least significant bit first. A one-bit serial adder and carry flop per neuron add the product into a 16-bit accumulator held as a rotating shift register.

A pattern starts with a one-cycle start pulse. That pulse clears every accumulator, the overflow flags, the neuron outputs and the input count. The host then offers eight input bits, one at a time, through a valid/ready handshake. Each accepted bit keeps the array busy for sixteen clock cycles. When the last bit of the eighth input has been added, a done pulse appears and each neuron drives a hard-limited decision: 1 when its sum reaches its threshold. A per-neuron sticky flag reports whether any addition in the pattern overflowed the 16-bit accumulator. Because the accumulator is only 16 bits wide, this flag tells the host when a pattern's fan-in has exceeded what the accumulator can represent.

Top module: `nslice_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `in_ready` is 1 and `done`, `fire` and `ovf` are all 0.
- R2: A cycle with `wr_en` high stores `wr_data` into neuron `wr_neuron`. When `wr_idx` is 0 to 7 it becomes the weight for that input position. When `wr_idx` is 8 it becomes that neuron's threshold. Writes to other neurons or positions are left unchanged.
- R3: An input bit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly sixteen cycles and returns to 1 afterwards, unless the accepted bit was the eighth of the pattern.
- R4: Each neuron's sum is the two's-complement total of the weights whose input bit was 1, taken in input order (input k uses weight position k). A 0 bit adds nothing, and the total wraps modulo 2^16.
- R5: After a pattern completes, `fire[n]` is 1 when neuron n's signed sum is greater than or equal to its signed threshold, and 0 otherwise. Equality counts as firing.
- R6: `done` is high for exactly one cycle: the cycle after the sixteenth serial cycle of the eighth input. `fire` changes at that same moment and holds until the next start pulse.
- R7: `ovf[n]` sets when any addition into neuron n's accumulator produces a signed overflow. It stays set for the rest of the pattern, even if later additions bring the sum back into range.
- R8: After the eighth input of a pattern, `in_ready` stays 0, and `in_valid` has no effect on `done`, `fire` or `ovf` until the next start pulse.
- R9: A `pat_start` pulse takes priority over everything else, including an input that is part-way through its serial cycles. In the following cycle `fire` and `ovf` are 0, `in_ready` is 1, and the next accepted bit counts as input 0 of a fresh sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight or threshold write strobe |
| wr_neuron | input | 3 | Neuron selected for the write |
| wr_idx | input | 4 | 0 to 7 selects a weight position, 8 selects the threshold |
| wr_data | input | 16 | Signed value to store |
| pat_start | input | 1 | Begin a new pattern; clears sums, flags and outputs |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Binary input value |
| in_ready | output | 1 | Array is idle and can take another input this pattern |
| done | output | 1 | One-cycle pulse when the pattern's decision is ready |
| fire | output | 8 | Hard-limited neuron outputs |
| ovf | output | 8 | Sticky per-neuron accumulator overflow flags |

## Verification
The assertions check the handshake and flag rules on every cycle. These are: the busy period that follows each accepted bit, the single-cycle width of `done`, the absence of readiness once a decision is out, the rule that overflow flags only clear on a start pulse, the rule that `fire` changes only with `done` or a start, and the cleared state after a start. The arithmetic itself can only be shown by the bench's scenarios, which compare each neuron's decision and overflow flag against sums computed independently. These scenarios cover mixed-sign weights, a sum exactly equal to the threshold, positive and negative overflow, an input aborted mid-shift, and input offered after the eighth bit.

// File: rtl/nslice_pkg.sv
package nslice_pkg;
  typedef enum logic {
    CTL_IDLE  = 1'b0,
    CTL_SHIFT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/nslice_weights.sv
// Weight and threshold storage; one read port selects one weight bit per neuron.
module nslice_weights #(
  parameter int NRN = 8,
  parameter int WW  = 16,
  parameter int NIN = 8,
  localparam int NW = $clog2(NRN),
  localparam int IW = $clog2(NIN + 1),
  localparam int IA = $clog2(NIN),
  localparam int BW = $clog2(WW)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [NW-1:0]           wr_neuron,
  input  logic [IW-1:0]           wr_idx,
  input  logic [WW-1:0]           wr_data,
  input  logic [IW-1:0]           rd_input,
  input  logic [BW-1:0]           rd_bit,
  output logic [NRN-1:0]          wbit,
  output logic [NRN-1:0][WW-1:0]  thr
);
  localparam logic [IW-1:0] THR_SEL = IW'(NIN);

  logic [WW-1:0] wmem [NRN][NIN];
  logic [WW-1:0] tmem [NRN];

  for (genvar g = 0; g < NRN; g++) begin : g_nrn
    logic sel;
    assign sel = wr_en && (wr_neuron == NW'(g));

    // storage array: no reset, written before use
    always_ff @(posedge clk) begin
      if (sel && (wr_idx < THR_SEL)) begin
        wmem[g][wr_idx[IA-1:0]] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && (wr_idx == THR_SEL)) begin
        tmem[g] <= wr_data;
      end
    end

    always_comb begin
      wbit[g] = wmem[g][rd_input[IA-1:0]][rd_bit];
      thr[g]  = tmem[g];
    end
  end
endmodule

// File: rtl/nslice_ctrl.sv
// Sequencer: input handshake, serial bit counter, input counter, done pulse.
module nslice_ctrl
  import nslice_pkg::*;
#(
  parameter int WW  = 16,
  parameter int NIN = 8,
  localparam int IW = $clog2(NIN + 1),
  localparam int BW = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat_start,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          in_ready,
  output logic          step,
  output logic          last_bit,
  output logic          commit,
  output logic          bit_val,
  output logic [BW-1:0] bit_idx,
  output logic [IW-1:0] inp_idx,
  output logic          done
);
  localparam logic [IW-1:0] CNT_FULL = IW'(NIN);
  localparam logic [IW-1:0] CNT_LAST = IW'(NIN - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WW - 1);

  ctl_state_e    st_q, st_d;
  logic [BW-1:0] bix_q, bix_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic          bv_q, bv_d;
  logic          dn_q, dn_d;
  logic          accept;

  always_comb begin
    in_ready = (st_q == CTL_IDLE) && (cnt_q != CNT_FULL);
    accept   = in_valid && in_ready;
    step     = (st_q == CTL_SHIFT);
    last_bit = (bix_q == BIT_LAST);
    commit   = step && last_bit && (cnt_q == CNT_LAST);

    st_d  = st_q;
    bix_d = bix_q;
    cnt_d = cnt_q;
    bv_d  = bv_q;
    dn_d  = 1'b0;
    if (pat_start) begin
      st_d  = CTL_IDLE;
      bix_d = '0;
      cnt_d = '0;
    end else if (accept) begin
      st_d  = CTL_SHIFT;
      bix_d = '0;
      bv_d  = in_bit;
    end else if (step) begin
      bix_d = bix_q + 1'b1;
      if (last_bit) begin
        st_d  = CTL_IDLE;
        bix_d = '0;
        cnt_d = cnt_q + 1'b1;
        dn_d  = commit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CTL_IDLE;
      bix_q <= '0;
      cnt_q <= '0;
      bv_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bix_q <= bix_d;
      cnt_q <= cnt_d;
      bv_q  <= bv_d;
      dn_q  <= dn_d;
    end
  end

  assign bit_val = bv_q;
  assign bit_idx = bix_q;
  assign inp_idx = cnt_q;
  assign done    = dn_q;
endmodule

// File: rtl/nslice_cell.sv
// One neuron: serial adder into a rotating accumulator, sticky overflow, decision.
module nslice_cell #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          last_bit,
  input  logic          commit,
  input  logic          in_bit,
  input  logic          wbit,
  input  logic [WW-1:0] thr,
  output logic          fire,
  output logic          ovf
);
  logic [WW-1:0] acc_q, acc_d;
  logic          cy_q, cy_d;
  logic          ovf_q, ovf_d;
  logic          fire_q, fire_d;
  logic          op_a, op_b, sum_b, cy_out;

  always_comb begin
    op_a   = acc_q[0];
    op_b   = in_bit & wbit;
    sum_b  = op_a ^ op_b ^ cy_q;
    cy_out = (op_a & op_b) | (op_a & cy_q) | (op_b & cy_q);

    acc_d  = acc_q;
    cy_d   = cy_q;
    ovf_d  = ovf_q;
    fire_d = fire_q;
    if (clr) begin
      acc_d  = '0;
      cy_d   = 1'b0;
      ovf_d  = 1'b0;
      fire_d = 1'b0;
    end else if (step) begin
      acc_d = {sum_b, acc_q[WW-1:1]};
      cy_d  = last_bit ? 1'b0 : cy_out;
      // carry into the sign bit differs from carry out: signed overflow
      if (last_bit && (cy_q ^ cy_out)) begin
        ovf_d = 1'b1;
      end
      if (commit) begin
        fire_d = ($signed(acc_d) >= $signed(thr));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cy_q   <= 1'b0;
      ovf_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cy_q   <= cy_d;
      ovf_q  <= ovf_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/nslice_top.sv
module nslice_top #(
  parameter int NRN = 8,
  parameter int WW  = 16,
  parameter int NIN = 8,
  localparam int NW = $clog2(NRN),
  localparam int IW = $clog2(NIN + 1),
  localparam int BW = $clog2(WW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NW-1:0]  wr_neuron,
  input  logic [IW-1:0]  wr_idx,
  input  logic [WW-1:0]  wr_data,
  input  logic           pat_start,
  input  logic           in_valid,
  input  logic           in_bit,
  output logic           in_ready,
  output logic           done,
  output logic [NRN-1:0] fire,
  output logic [NRN-1:0] ovf
);
  logic                   step, last_bit, commit, bit_val;
  logic [BW-1:0]          bit_idx;
  logic [IW-1:0]          inp_idx;
  logic [NRN-1:0]         wbit;
  logic [NRN-1:0][WW-1:0] thr;

  nslice_ctrl #(.WW(WW), .NIN(NIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pat_start(pat_start),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .step(step), .last_bit(last_bit), .commit(commit), .bit_val(bit_val),
    .bit_idx(bit_idx), .inp_idx(inp_idx), .done(done)
  );

  nslice_weights #(.NRN(NRN), .WW(WW), .NIN(NIN)) u_wts (
    .clk(clk), .wr_en(wr_en), .wr_neuron(wr_neuron), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_input(inp_idx), .rd_bit(bit_idx),
    .wbit(wbit), .thr(thr)
  );

  for (genvar n = 0; n < NRN; n++) begin : g_cell
    nslice_cell #(.WW(WW)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(pat_start), .step(step),
      .last_bit(last_bit), .commit(commit), .in_bit(bit_val),
      .wbit(wbit[n]), .thr(thr[n]), .fire(fire[n]), .ovf(ovf[n])
    );
  end
endmodule

// File: rtl/nslice_checker.sv
module nslice_checker #(
  parameter int NRN = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pat_start,
  input logic           in_valid,
  input logic           in_ready,
  input logic           done,
  input logic [NRN-1:0] fire,
  input logic [NRN-1:0] ovf
);
  // R3
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pat_start) |=> !in_ready);

  // R6
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  fire_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fire) |-> (done || $past(pat_start)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_start |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R8
  no_ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> (ovf == '0 && fire == '0 && in_ready && !done));
endmodule

bind nslice_top nslice_checker #(.NRN(NRN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_start(pat_start), .in_valid(in_valid),
  .in_ready(in_ready), .done(done), .fire(fire), .ovf(ovf)
);

// File: tb/tb_nslice_top.sv
module tb_nslice_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRN = 8;
  localparam int NIN = 8;

  logic        clk, rst_n;
  logic        wr_en;
  logic [2:0]  wr_neuron;
  logic [3:0]  wr_idx;
  logic [15:0] wr_data;
  logic        pat_start, in_valid, in_bit;
  logic        in_ready, done;
  logic [7:0]  fire, ovf;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] wts [NRN][NIN];
  logic [15:0] thr [NRN];

  nslice_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_neuron(wr_neuron),
    .wr_idx(wr_idx), .wr_data(wr_data), .pat_start(pat_start),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .done(done), .fire(fire), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int n, input int idx, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_neuron = 3'(n); wr_idx = 4'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < NIN) wts[n][idx] = v; else thr[n] = v;
  endtask

  task automatic start_pattern();
    @(negedge clk);
    pat_start = 1'b1;
    @(negedge clk);
    pat_start = 1'b0;
    check("R9 ovf cleared", 32'(ovf), 32'h0);
    check("R9 fire cleared", 32'(fire), 32'h0);
    check("R9 ready after start", 32'(in_ready), 32'h1);
  endtask

  // caller is at a negedge; leaves at the negedge where done or ready is visible
  task automatic send_bit(input logic b, input bit last);
    check("R3 ready before input", 32'(in_ready), 32'h1);
    in_valid = 1'b1; in_bit = b;
    @(negedge clk);
    in_valid = 1'b0; in_bit = 1'b0;
    repeat (15) @(negedge clk);
    check("R3 busy 16th cycle", 32'(in_ready), 32'h0);
    check("R6 no early done", 32'(done), 32'h0);
    @(negedge clk);
    check("R3/R8 ready after serial", 32'(in_ready), last ? 32'h0 : 32'h1);
    check("R6 done at end", 32'(done), last ? 32'h1 : 32'h0);
  endtask

  function automatic void model(input logic [7:0] bits, output logic [7:0] ef, output logic [7:0] eo);
    for (int n = 0; n < NRN; n++) begin
      logic [15:0] s;
      logic [15:0] ns;
      s = '0; eo[n] = 1'b0;
      for (int i = 0; i < NIN; i++) begin
        if (bits[i]) begin
          ns = s + wts[n][i];
          if ((s[15] == wts[n][i][15]) && (ns[15] != s[15])) eo[n] = 1'b1;
          s = ns;
        end
      end
      ef[n] = ($signed(s) >= $signed(thr[n]));
    end
  endfunction

  task automatic run_pattern(input logic [7:0] bits, input string tag);
    logic [7:0] ef, eo;
    model(bits, ef, eo);
    start_pattern();
    for (int i = 0; i < NIN; i++) send_bit(bits[i], i == NIN - 1);
    check({"R2/R4/R5 fire ", tag}, 32'(fire), 32'(ef));
    check({"R7 ovf ", tag}, 32'(ovf), 32'(eo));
    @(negedge clk);
    check("R6 done one cycle", 32'(done), 32'h0);
    check("R6 fire held", 32'(fire), 32'(ef));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_neuron = '0; wr_idx = '0; wr_data = '0;
    pat_start = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(in_ready), 32'h1);
    check("R1 done in reset", 32'(done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fire after reset", 32'(fire), 32'h0);
    check("R1 ovf after reset", 32'(ovf), 32'h0);
    check("R1 ready after reset", 32'(in_ready), 32'h1);
  endtask

  task automatic t_mixed();
    for (int n = 0; n < NRN; n++) begin
      for (int i = 0; i < NIN; i++) load(n, i, 16'((n * 1237 + i * 2099) % 5000 - 2400));
      load(n, NIN, 16'(n * 700 - 2800));
    end
    run_pattern(8'hFF, "all ones");
    run_pattern(8'hA5, "0xA5");
    run_pattern(8'h3C, "0x3C");
    run_pattern(8'h00, "all zeros");
  endtask

  task automatic t_equal();
    // neuron 3 threshold exactly equals its sum for 0x81, neuron 4 one above
    load(3, 0, 16'd100); load(3, 7, 16'hFFCE); load(3, NIN, 16'd50);
    load(4, 0, 16'd100); load(4, 7, 16'hFFCE); load(4, NIN, 16'd51);
    run_pattern(8'h81, "threshold equality");
    check("R5 equal fires", 32'(fire[3]), 32'h1);
    check("R5 one above stays low", 32'(fire[4]), 32'h0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < NIN; i++) begin
      load(0, i, 16'h4000);                       // positive overflow on 2nd add
      load(1, i, (i < 2) ? 16'h8000 : 16'h0000);  // negative overflow, then stays
      load(2, i, (i % 2 == 0) ? 16'h7FFF : 16'h8001); // overflow then back in range
    end
    run_pattern(8'h03, "two adds");
    check("R7 positive overflow", 32'(ovf[0]), 32'h1);
    check("R7 negative overflow", 32'(ovf[1]), 32'h1);
    run_pattern(8'h0D, "sticky");
    check("R7 sticky after recovery", 32'(ovf[2]), 32'h1);
    start_pattern();
  endtask

  task automatic t_ignore();
    logic [7:0] f0, o0;
    run_pattern(8'h5A, "before extra input");
    f0 = fire; o0 = ovf;
    for (int k = 0; k < 40; k++) begin
      in_valid = 1'b1; in_bit = 1'b1;
      @(negedge clk);
      if (done) check("R8 done stays low", 32'(done), 32'h0);
    end
    in_valid = 1'b0; in_bit = 1'b0;
    check("R8 ready stays low", 32'(in_ready), 32'h0);
    check("R8 fire unchanged", 32'(fire), 32'(f0));
    check("R8 ovf unchanged", 32'(ovf), 32'(o0));
  endtask

  task automatic t_abort();
    logic [7:0] ef, eo;
    start_pattern();
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_bit = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 busy before abort", 32'(in_ready), 32'h0);
    run_pattern(8'hC3, "after abort");
    model(8'hC3, ef, eo);
    check("R9 fresh sum after abort", 32'(fire), 32'(ef));
  endtask

  initial begin
    t_reset();
    t_mixed();
    t_equal();
    t_overflow();
    t_ignore();
    t_abort();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule